// File: doc/BRIEF.md
# Multi-Master Semaphore Bank

This block holds a set of lock words that several CPU cores use to guard shared resources. Each core has its own request port into a small word-addressed register space. A request carries a sideband master code that names the core. Each semaphore stores a held flag, an owner core code and an owner process number. A core takes a semaphore in one of two ways. It can write a lock word and read it back, or it can read a dedicated read-to-lock address and get the outcome in the same access. A core gives a semaphore back by writing a release word that names the exact owner.

A core can also free every semaphore tagged with one core code in a single write, provided that write carries the 16-bit release key that software stored earlier. Every interrupt bank sees each locked-to-free transition. A bank raises its interrupt line when the freed semaphore's bit is also enabled there.

Each access is decoded and applied in the cycle it is presented. The read result appears on the port's read bus after the next rising clock edge. That result reflects the state after the access took effect.

Top module: `sema_bank`

## Requirements
- R1: After reset every semaphore reads 0 (free, owner fields zero), the release key reads 0, all enable and status words read 0, and every irq line is low.
- R2: Writing a word with bit 31 set to semaphore address 0x00+s takes semaphore s only if it was free at the start of that cycle. The owner core code is written in bits 15:8 and the process number in bits 7:0. The readback word is {held bit 31, core code 15:8, process 7:0}. A lock write to a held semaphore leaves it unchanged.
- R3: A read of address 0x40+s while semaphore s is free takes it with the requesting port's master code and process number 0, and returns the resulting word.
- R4: A read of 0x40+s while semaphore s is held returns the current owner word and leaves the semaphore unchanged.
- R5: A write with bit 31 clear to 0x00+s frees semaphore s (the word becomes 0) only when both bits 15:8 and bits 7:0 equal the stored owner. Any other release write has no effect.
- R6: Address 0x80 holds a 16-bit release key, written from wdata bits 15:0 and read back zero-extended.
- R7: A write to 0x81 carrying key bits 31:16 and core code bits 15:8 frees every held semaphore whose owner core code matches, provided the key equals the stored key. With any other key nothing changes.
- R8: Each locked-to-free transition sets that semaphore's bit in the status word (0xA0+b) of every bank b. irq[b] is high while some bit is set in both the status word and the enable word (0x90+b) of bank b.
- R9: Writing 1s to 0xB0+b clears those status bits of bank b only. Other banks are untouched.
- R10: When ports try to take the same free semaphore in one cycle, the request whose master code maps to the lowest bank index wins, and only the winner's fields are stored. Master code 0x04 maps to bank 0, 0x08 maps to bank 1, and unknown codes rank below all known codes.
- R11: When a release and a take of the same held semaphore arrive in the same cycle, the semaphore ends free and the taker reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | NCORE | Per-port access strobe |
| bus_write | input | NCORE | Per-port write (1) or read (0) |
| bus_addr | input | 8*NCORE | Per-port word address |
| bus_wdata | input | 32*NCORE | Per-port write data |
| bus_mid | input | 8*NCORE | Per-port master core code |
| bus_rdata | output | 32*NCORE | Per-port read data, registered |
| irq | output | NCORE | Per-bank freed-semaphore interrupt |

## Verification
Two-step locks are tried by the owner and by an intruder, which shows that only a free semaphore can be taken. Release writes are tried with a wrong process number and then with the correct owner, which shows that a release needs both fields to match. Read-to-lock is tried on a free and on a held semaphore. Bulk release is tried with a wrong key and with the right one, while a semaphore owned by another core stays held. Simultaneous takes are issued with the master codes swapped relative to port order, which separates priority by bank index from priority by port position. A release paired with a take in the same cycle shows that a take only succeeds on a semaphore that was free at the start of the cycle. The status words of both banks are read after each release, which shows whether the event reaches every bank and whether each bank is cleared on its own.

// File: rtl/sema_pkg.sv
package sema_pkg;
    localparam int DW    = 32;
    localparam int AW    = 8;
    localparam int IDW   = 8;
    localparam int KW    = 16;
    localparam int IDXW  = 8;
    localparam int RANKW = 4;

    localparam int BASE_SEM  = 'h00;
    localparam int BASE_RLK  = 'h40;
    localparam int ADDR_KEY  = 'h80;
    localparam int ADDR_BULK = 'h81;
    localparam int BASE_IEN  = 'h90;
    localparam int BASE_ISTA = 'hA0;
    localparam int BASE_ICLR = 'hB0;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOCK2,
        OP_UNLOCK,
        OP_RLOCK,
        OP_KEYW,
        OP_BULK,
        OP_IENW,
        OP_ICLRW
    } op_e;

    typedef struct packed {
        logic           held;
        logic [IDW-1:0] cid;
        logic [IDW-1:0] pid;
    } sem_t;

    typedef struct packed {
        op_e             op;
        logic [IDXW-1:0] idx;
        logic [IDW-1:0]  cid;
        logic [IDW-1:0]  pid;
        logic [KW-1:0]   key;
        logic [DW-1:0]   data;
        logic [RANKW-1:0] rank;
    } preq_t;

    function automatic logic [DW-1:0] sem_word(sem_t s);
        return {s.held, 15'd0, s.cid, s.pid};
    endfunction
endpackage

// File: rtl/sema_req_decode.sv
module sema_req_decode
    import sema_pkg::*;
#(
    parameter int NSEM = 6,
    parameter int NCORE = 2,
    parameter logic [NCORE*IDW-1:0] CORE_TAGS = {8'h08, 8'h04}
) (
    input  logic           valid,
    input  logic           write,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic [IDW-1:0] mid,
    output preq_t          req
);
    always_comb begin
        req      = '0;
        req.op   = OP_NONE;
        req.cid  = wdata[15:8];
        req.pid  = wdata[7:0];
        req.key  = wdata[31:16];
        req.data = wdata;
        req.rank = RANKW'(NCORE);
        for (int b = NCORE - 1; b >= 0; b--) begin
            if (mid == CORE_TAGS[b*IDW +: IDW]) req.rank = RANKW'(b);
        end
        if (valid) begin
            for (int s = 0; s < NSEM; s++) begin
                if (addr == AW'(BASE_SEM + s) && write) begin
                    req.idx = IDXW'(s);
                    req.op  = wdata[31] ? OP_LOCK2 : OP_UNLOCK;
                end
                if (addr == AW'(BASE_RLK + s) && !write) begin
                    req.idx = IDXW'(s);
                    req.op  = OP_RLOCK;
                    req.cid = mid;
                    req.pid = '0;
                end
            end
            if (addr == AW'(ADDR_KEY) && write) req.op = OP_KEYW;
            if (addr == AW'(ADDR_BULK) && write) req.op = OP_BULK;
            for (int b = 0; b < NCORE; b++) begin
                if (addr == AW'(BASE_IEN + b) && write) begin
                    req.idx = IDXW'(b);
                    req.op  = OP_IENW;
                end
                if (addr == AW'(BASE_ICLR + b) && write) begin
                    req.idx = IDXW'(b);
                    req.op  = OP_ICLRW;
                end
            end
        end
    end
endmodule

// File: rtl/sema_cell.sv
module sema_cell
    import sema_pkg::*;
#(
    parameter int NPORT = 2,
    parameter int IDX = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  preq_t         req [NPORT],
    input  logic [KW-1:0] key_q,
    output sem_t          cur,
    output sem_t          nxt,
    output logic          freed
);
    logic             found;
    logic [RANKW-1:0] best;
    sem_t             win;
    logic             unused_bits;

    always_comb begin
        freed = 1'b0;
        found = 1'b0;
        best  = '1;
        win   = '0;
        unused_bits = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            unused_bits = unused_bits ^ (^req[p].data);
            if (cur.held && req[p].op == OP_UNLOCK && req[p].idx == IDXW'(IDX)
                && req[p].cid == cur.cid && req[p].pid == cur.pid)
                freed = 1'b1;
            if (cur.held && req[p].op == OP_BULK && req[p].key == key_q
                && req[p].cid == cur.cid)
                freed = 1'b1;
            if (!cur.held && (req[p].op == OP_LOCK2 || req[p].op == OP_RLOCK)
                && req[p].idx == IDXW'(IDX) && (!found || req[p].rank < best)) begin
                found    = 1'b1;
                best     = req[p].rank;
                win.held = 1'b1;
                win.cid  = req[p].cid;
                win.pid  = req[p].pid;
            end
        end
        nxt = cur;
        if (freed)      nxt = '0;
        else if (found) nxt = win;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    // R2 R4 R5
    held_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cur.held && !freed) |=> $stable(cur));
    // R2 R3
    take_chk: assert property (@(posedge clk) disable iff (rst)
        (!cur.held && found) |=> cur.held);
    // R5 R7 R11
    release_chk: assert property (@(posedge clk) disable iff (rst)
        freed |=> (cur == '0));
endmodule

// File: rtl/sema_irq_bank.sv
module sema_irq_bank
    import sema_pkg::*;
#(
    parameter int NSEM = 6,
    parameter int NPORT = 2,
    parameter int BANK = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  preq_t           req [NPORT],
    input  logic [NSEM-1:0] freed,
    output logic [NSEM-1:0] ien_n,
    output logic [NSEM-1:0] ista_n,
    output logic            irq
);
    logic [NSEM-1:0] ien_q, ista_q, clr, clr_only;
    logic            unused_bits;

    always_comb begin
        ien_n = ien_q;
        clr   = '0;
        unused_bits = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            unused_bits = unused_bits ^ (^{req[p].cid, req[p].pid, req[p].key,
                                            req[p].rank, req[p].data});
            if (req[p].op == OP_IENW && req[p].idx == IDXW'(BANK))
                ien_n = req[p].data[NSEM-1:0];
            if (req[p].op == OP_ICLRW && req[p].idx == IDXW'(BANK))
                clr = clr | req[p].data[NSEM-1:0];
        end
        ista_n   = (ista_q & ~clr) | freed;
        clr_only = clr & ~freed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= '0;
            ista_q <= '0;
        end else begin
            ien_q  <= ien_n;
            ista_q <= ista_n;
        end
    end

    assign irq = |(ien_q & ista_q);

    // R8
    freed_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|freed) |=> ((ista_q & $past(freed)) == $past(freed)));
    // R9
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (|clr_only) |=> ((ista_q & $past(clr_only)) == '0));
endmodule

// File: rtl/sema_bank.sv
module sema_bank
    import sema_pkg::*;
#(
    parameter int NSEM = 6,
    parameter int NCORE = 2,
    parameter logic [NCORE*8-1:0] CORE_TAGS = {8'h08, 8'h04}
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCORE-1:0]    bus_valid,
    input  logic [NCORE-1:0]    bus_write,
    input  logic [NCORE*8-1:0]  bus_addr,
    input  logic [NCORE*32-1:0] bus_wdata,
    input  logic [NCORE*8-1:0]  bus_mid,
    output logic [NCORE*32-1:0] bus_rdata,
    output logic [NCORE-1:0]    irq
);
    preq_t           req [NCORE];
    sem_t            sem_q   [NSEM];
    sem_t            sem_nxt [NSEM];
    logic [NSEM-1:0] freed;
    logic [NSEM-1:0] ien_n  [NCORE];
    logic [NSEM-1:0] ista_n [NCORE];
    logic [KW-1:0]   key_q, key_n;
    logic [NCORE-1:0] key_wr;
    logic [DW-1:0]   rd_q [NCORE];
    logic [DW-1:0]   rd_n [NCORE];

    for (genvar p = 0; p < NCORE; p++) begin : g_port
        sema_req_decode #(.NSEM(NSEM), .NCORE(NCORE), .CORE_TAGS(CORE_TAGS)) u_dec (
            .valid (bus_valid[p]),
            .write (bus_write[p]),
            .addr  (bus_addr[p*AW +: AW]),
            .wdata (bus_wdata[p*DW +: DW]),
            .mid   (bus_mid[p*IDW +: IDW]),
            .req   (req[p])
        );
        assign bus_rdata[p*DW +: DW] = rd_q[p];
    end

    for (genvar s = 0; s < NSEM; s++) begin : g_sem
        sema_cell #(.NPORT(NCORE), .IDX(s)) u_cell (
            .clk   (clk),
            .rst   (rst),
            .req   (req),
            .key_q (key_q),
            .cur   (sem_q[s]),
            .nxt   (sem_nxt[s]),
            .freed (freed[s])
        );
    end

    for (genvar b = 0; b < NCORE; b++) begin : g_bank
        sema_irq_bank #(.NSEM(NSEM), .NPORT(NCORE), .BANK(b)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .req    (req),
            .freed  (freed),
            .ien_n  (ien_n[b]),
            .ista_n (ista_n[b]),
            .irq    (irq[b])
        );
    end

    always_comb begin
        key_n = key_q;
        for (int p = 0; p < NCORE; p++) begin
            key_wr[p] = (req[p].op == OP_KEYW);
            if (key_wr[p]) key_n = req[p].data[KW-1:0];
        end
    end

    always_comb begin
        for (int p = 0; p < NCORE; p++) begin
            rd_n[p] = '0;
            if (bus_valid[p] && !bus_write[p]) begin
                for (int s = 0; s < NSEM; s++) begin
                    if (bus_addr[p*AW +: AW] == AW'(BASE_SEM + s) ||
                        bus_addr[p*AW +: AW] == AW'(BASE_RLK + s))
                        rd_n[p] = sem_word(sem_nxt[s]);
                end
                if (bus_addr[p*AW +: AW] == AW'(ADDR_KEY))
                    rd_n[p] = DW'(key_n);
                for (int b = 0; b < NCORE; b++) begin
                    if (bus_addr[p*AW +: AW] == AW'(BASE_IEN + b))
                        rd_n[p] = DW'(ien_n[b]);
                    if (bus_addr[p*AW +: AW] == AW'(BASE_ISTA + b))
                        rd_n[p] = DW'(ista_n[b]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
            for (int p = 0; p < NCORE; p++) rd_q[p] <= '0;
        end else begin
            key_q <= key_n;
            for (int p = 0; p < NCORE; p++) rd_q[p] <= rd_n[p];
        end
    end

    // R6
    key_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(|key_wr) |=> $stable(key_q));
endmodule

// File: tb/sema_bank_bench.sv
module sema_bank_bench;
    localparam int NC = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NC-1:0]     bus_valid;
    logic [NC-1:0]     bus_write;
    logic [NC*8-1:0]   bus_addr;
    logic [NC*32-1:0]  bus_wdata;
    logic [NC*8-1:0]   bus_mid;
    logic [NC*32-1:0]  bus_rdata;
    logic [NC-1:0]     irq;

    sema_bank u_sema_bank (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_mid(bus_mid),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    typedef struct {
        int          port;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t pend[$];
    item_t ready[$];
    int    n_vec = 0;
    int    n_bad = 0;
    logic [7:0] mid_of [NC];
    bit    done = 1'b0;

    task automatic clear_bus();
        bus_valid = '0; bus_write = '0; bus_addr = '0; bus_wdata = '0;
        for (int p = 0; p < NC; p++) bus_mid[p*8 +: 8] = mid_of[p];
    endtask

    task automatic put(int p, bit we, logic [7:0] a, logic [31:0] d);
        bus_valid[p]        = 1'b1;
        bus_write[p]        = we;
        bus_addr[p*8 +: 8]  = a;
        bus_wdata[p*32 +: 32] = d;
    endtask

    task automatic wr(int p, logic [7:0] a, logic [31:0] d);
        @(negedge clk); clear_bus(); put(p, 1'b1, a, d);
    endtask

    task automatic rd(int p, logic [7:0] a, logic [31:0] e, string tag);
        item_t it;
        @(negedge clk); clear_bus(); put(p, 1'b0, a, 32'h0);
        it.port = p; it.exp = e; it.tag = tag;
        pend.push_back(it);
    endtask

    task automatic step();
        @(negedge clk); clear_bus();
    endtask

    task automatic chk(logic [31:0] got, logic [31:0] e, string tag);
        n_vec++;
        if (got !== e) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, e);
        end
    endtask

    // monitor: compare each read one edge after it was presented
    initial begin
        forever begin
            @(posedge clk);
            ready = pend;
            pend.delete();
            @(negedge clk);
            foreach (ready[i])
                chk(bus_rdata[ready[i].port*32 +: 32], ready[i].exp, ready[i].tag);
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        item_t it;
        mid_of[0] = 8'h04; mid_of[1] = 8'h08;
        clear_bus();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(32'(irq), 32'h0, "R1 irq");
        rd(0, 8'h00, 32'h0, "R1 sem0");
        rd(1, 8'h80, 32'h0, "R1 key");
        rd(0, 8'hA0, 32'h0, "R1 status0");
        rd(1, 8'h90, 32'h0, "R1 enable1");
        // enables: bank0 all, bank1 only sem0
        wr(0, 8'h90, 32'h3F);
        wr(0, 8'h91, 32'h01);
        // R2 two-step lock
        wr(0, 8'h01, 32'h8000_0421);
        rd(0, 8'h01, 32'h8000_0421, "R2 owner readback");
        wr(1, 8'h01, 32'h8000_0805);
        rd(1, 8'h01, 32'h8000_0421, "R2 intruder lock ignored");
        // R5 release
        wr(1, 8'h01, 32'h0000_0422);
        rd(1, 8'h01, 32'h8000_0421, "R5 wrong pid ignored");
        rd(0, 8'hA0, 32'h0, "R5 no event on bad release");
        wr(0, 8'h01, 32'h0000_0421);
        rd(0, 8'h01, 32'h0, "R5 owner release");
        step();
        chk(32'(irq), 32'h1, "R8 irq bank0 only");
        rd(0, 8'hA0, 32'h02, "R8 status bank0");
        rd(1, 8'hA1, 32'h02, "R8 status bank1");
        // R9 per-bank clear
        wr(0, 8'hB0, 32'h02);
        rd(0, 8'hA1, 32'h02, "R9 bank1 kept");
        rd(0, 8'hA0, 32'h0, "R9 bank0 cleared");
        step();
        chk(32'(irq), 32'h0, "R9 irq dropped");
        wr(1, 8'hB1, 32'h3F);
        // R3/R4 read-to-lock
        rd(1, 8'h42, 32'h8000_0800, "R3 read-lock free");
        rd(0, 8'h42, 32'h8000_0800, "R4 read-lock held");
        rd(0, 8'h02, 32'h8000_0800, "R4 state unchanged");
        // R6 key
        wr(0, 8'h80, 32'h0000_BEEF);
        rd(1, 8'h80, 32'h0000_BEEF, "R6 key readback");
        wr(1, 8'h80, 32'hFFFF_1234);
        rd(0, 8'h80, 32'h0000_1234, "R6 key width");
        wr(0, 8'h80, 32'h0000_BEEF);
        // R7 bulk release
        wr(0, 8'h00, 32'h8000_0401);
        wr(0, 8'h03, 32'h8000_0402);
        wr(1, 8'h81, 32'hBEEE_0400);
        rd(0, 8'h00, 32'h8000_0401, "R7 wrong key ignored");
        wr(1, 8'h81, 32'hBEEF_0400);
        rd(0, 8'h00, 32'h0, "R7 sem0 freed");
        rd(0, 8'h03, 32'h0, "R7 sem3 freed");
        rd(0, 8'h02, 32'h8000_0800, "R7 other core kept");
        rd(1, 8'hA0, 32'h09, "R8 bulk events");
        wr(0, 8'hB0, 32'h3F);
        wr(0, 8'hB1, 32'h3F);
        // R10 contention, codes swapped against port order
        mid_of[0] = 8'h08; mid_of[1] = 8'h04;
        @(negedge clk); clear_bus();
        put(0, 1'b0, 8'h44, 32'h0); put(1, 1'b0, 8'h44, 32'h0);
        it.port = 0; it.exp = 32'h8000_0400; it.tag = "R10 loser sees winner"; pend.push_back(it);
        it.port = 1; it.exp = 32'h8000_0400; it.tag = "R10 winner"; pend.push_back(it);
        mid_of[0] = 8'h04; mid_of[1] = 8'h08;
        @(negedge clk); clear_bus();
        put(0, 1'b1, 8'h05, 32'h8000_0407); put(1, 1'b1, 8'h05, 32'h8000_0809);
        rd(1, 8'h05, 32'h8000_0407, "R10 two-step winner");
        // R11 release and take together
        @(negedge clk); clear_bus();
        put(0, 1'b1, 8'h05, 32'h0000_0407); put(1, 1'b0, 8'h45, 32'h0);
        it.port = 1; it.exp = 32'h0; it.tag = "R11 take loses to release"; pend.push_back(it);
        rd(0, 8'h05, 32'h0, "R11 ends free");
        step(); step(); step();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule